// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

The walker executes a list of transfer descriptors that software has built in memory. Each descriptor is a 32-byte record of eight little-endian 32-bit words. The walker reads all eight words of a descriptor and examines its hardware-ownership flag.

If the descriptor is owned, the walker issues one command to an external data mover. It then waits for the mover's response and writes the completion result back into the same descriptor. After that it follows the next-descriptor pointer. The first descriptor that is not owned ends the chain.

Memory is reached through a single 32-bit word port. A request stays asserted until the same-cycle acknowledge arrives. Three one-cycle event outputs tell a neighbouring register block when a descriptor finishes, when the chain ends and when an error stops the walk.

The descriptor layout used by the walker:

| Byte offset | Content |
|---|---|
| +0 | Source (read) address |
| +8 | Destination (write) address |
| +16 | Pointer to the next descriptor |
| +4, +12, +20 | Ignored |
| +24 | Bits [15:0]: requested byte count. Bits [23:16]: read burst. Bits [31:24]: write burst |
| +28 | Bits [15:0]: transferred byte count. Bits [23:16]: status byte. Bits [31:24]: control byte |

Control byte fields:
- bit 0: end-of-packet request
- bit 1: fixed read address
- bit 2: fixed write address
- bits 3 to 6: channel, always zero
- bit 7: hardware-owned

Status byte fields:
- bits 0 to 5: error, length, CRC, truncation, PHY and collision flags
- bit 6: reserved
- bit 7: end-of-packet seen on receive

A requested count of zero is passed through unchanged. The mover reads it as "transfer until end of packet".

States and transitions:

| State | Role | Transition |
|---|---|---|
| ST_IDLE | Waiting for a start | `start_i` moves to ST_FETCH |
| ST_FETCH | Eight word reads | The eighth acknowledge moves to ST_CHECK |
| ST_CHECK | Ownership test | Owned moves to ST_ISSUE. Not owned moves to ST_IDLE and pulses the chain-done event |
| ST_ISSUE | Command offered to the mover | `cmd_ready_i` moves to ST_WAIT |
| ST_WAIT | Waiting for the mover | `resp_valid_i` moves to ST_WBACK |
| ST_WBACK | One write-back | The acknowledge moves to ST_FETCH for the next descriptor, or to ST_IDLE on a stopping error |

Top module: `desc_chain_walker`

## Requirements
- R1: After reset the walker is idle: `busy_o`, `mem_req_o`, `cmd_valid_o` and all three event outputs are low.
- R2: A start makes the walker read the eight words of the descriptor at `start_addr_i`, at byte offsets 0, 4, ... 28 in ascending order, one read per acknowledge.
- R3: A descriptor whose control byte bit 7 (bit 31 of the word at +28) is 0 produces no command and no write-back. `chain_done_o` pulses for one cycle and `busy_o` is low in that same cycle.
- R4: An owned descriptor produces exactly one command with these fields:
  - `cmd_rd_addr_o` = word +0
  - `cmd_wr_addr_o` = word +8
  - `cmd_len_o` = bits [15:0] of word +24, a zero passed through unchanged
  - `cmd_flags_o` = control bits {2,1,0}
- R5: While `cmd_valid_o` is high and `cmd_ready_i` is low, the command and all its fields hold steady.
- R6: After the response, the walker does one write to descriptor address +28. The data holds the response byte count in bits [15:0], the response status byte in bits [23:16] and the control byte in bits [31:24].
- R7: In the written-back control byte, bit 7 is 0 when `keep_own_i` is 0 and 1 when it is 1. Control bits 0 to 6 are kept as fetched.
- R8: `desc_done_o` pulses for one cycle, in the cycle after each acknowledged write-back.
- R9: After a write-back the walker fetches the descriptor at the address held in word +16.
- R10: If the response status bit 0 is set and `stop_on_err_i` is 1, the walker stops after the write-back. `err_stop_o` pulses while `busy_o` is low, and no further descriptor is read. With `stop_on_err_i` at 0 the walk continues.
- R11: A start while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a walk, honoured only when idle |
| start_addr_i | input | 32 | Address of the first descriptor |
| keep_own_i | input | 1 | 1 leaves the ownership bit set on write-back |
| stop_on_err_i | input | 1 | 1 halts the walk on a mover error |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata_i | input | 32 | Read data |
| cmd_valid_o | output | 1 | Transfer command offered |
| cmd_ready_i | input | 1 | Mover accepts the command |
| cmd_rd_addr_o | output | 32 | Source address |
| cmd_wr_addr_o | output | 32 | Destination address |
| cmd_len_o | output | 16 | Requested byte count (0 means until end of packet) |
| cmd_flags_o | output | 3 | {fixed write, fixed read, end-of-packet} |
| resp_valid_i | input | 1 | Mover completion |
| resp_bytes_i | input | 16 | Bytes actually moved |
| resp_status_i | input | 8 | Per-packet status flags |
| busy_o | output | 1 | Walker not idle |
| desc_done_o | output | 1 | One descriptor completed |
| chain_done_o | output | 1 | Non-owned descriptor reached |
| err_stop_o | output | 1 | Walk halted on an error |

## Verification
The bench acknowledges memory in the same cycle as the request, so the eight reads fill eight consecutive cycles starting the cycle after the start is seen. The command appears two cycles after the last read. The write-back follows one cycle after the response.

All three events are registered, so each one shows up one cycle after the edge that causes it, in the first cycle with `busy_o` low when the walk ends. The bench records every acknowledged memory access, every accepted command and every event at the rising edge. After `busy_o` falls it waits one more edge before comparing those logs, so each result is read only after the cycle it is due. Steadiness of a held command is sampled on falling edges.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT,
        ST_WBACK
    } dcw_state_e;

    localparam int DESC_WORDS = 8;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int LEN_W      = 16;
    localparam int BYTE_W     = 8;
    localparam int OWN_BIT    = 7;
    localparam int FLAG_W     = 3;
    // word indices inside a descriptor
    localparam int W_RADDR    = 0;
    localparam int W_WADDR    = 2;
    localparam int W_NEXT     = 4;
    localparam int W_LEN      = 6;
    localparam int W_DONE     = 7;
    localparam int DONE_OFFS  = W_DONE * 4;
endpackage

// File: rtl/dcw_capture.sv
module dcw_capture
    import dcw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [31:0]       rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] next_ptr,
    output logic [LEN_W-1:0]  req_len,
    output logic [BYTE_W-1:0] ctrl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr  <= '0;
            wr_addr  <= '0;
            next_ptr <= '0;
            req_len  <= '0;
            ctrl     <= '0;
        end else if (cap_en) begin
            unique case (int'(word_idx))
                W_RADDR: rd_addr  <= rdata[ADDR_W-1:0];
                W_WADDR: wr_addr  <= rdata[ADDR_W-1:0];
                W_NEXT:  next_ptr <= rdata[ADDR_W-1:0];
                W_LEN:   req_len  <= rdata[LEN_W-1:0];
                W_DONE:  ctrl     <= rdata[31 -: BYTE_W];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dcw_wb_pack.sv
module dcw_wb_pack
    import dcw_pkg::*;
(
    input  logic [BYTE_W-1:0] ctrl,
    input  logic              keep_own,
    input  logic [LEN_W-1:0]  bytes,
    input  logic [BYTE_W-1:0] status,
    output logic [31:0]       wdata
);
    logic [BYTE_W-1:0] ctrl_wb;

    always_comb begin
        ctrl_wb          = ctrl;
        ctrl_wb[OWN_BIT] = keep_own;
        wdata            = {ctrl_wb, status, bytes};
    end
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
    import dcw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              keep_own_i,
    input  logic              stop_on_err_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [ADDR_W-1:0] cmd_rd_addr_o,
    output logic [ADDR_W-1:0] cmd_wr_addr_o,
    output logic [LEN_W-1:0]  cmd_len_o,
    output logic [FLAG_W-1:0] cmd_flags_o,
    input  logic              resp_valid_i,
    input  logic [LEN_W-1:0]  resp_bytes_i,
    input  logic [BYTE_W-1:0] resp_status_i,
    output logic              busy_o,
    output logic              desc_done_o,
    output logic              chain_done_o,
    output logic              err_stop_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    dcw_state_e        state_q, state_d;
    logic [ADDR_W-1:0] cur_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  xfer_q;
    logic [BYTE_W-1:0] stat_q;
    logic [ADDR_W-1:0] next_ptr;
    logic [BYTE_W-1:0] ctrl;
    logic              halt_now;

    dcw_capture #(.ADDR_W(ADDR_W)) cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (state_q == ST_FETCH && mem_ack_i),
        .word_idx (idx_q),
        .rdata    (mem_rdata_i),
        .rd_addr  (cmd_rd_addr_o),
        .wr_addr  (cmd_wr_addr_o),
        .next_ptr (next_ptr),
        .req_len  (cmd_len_o),
        .ctrl     (ctrl)
    );

    dcw_wb_pack pack_i (
        .ctrl     (ctrl),
        .keep_own (keep_own_i),
        .bytes    (xfer_q),
        .status   (stat_q),
        .wdata    (mem_wdata_o)
    );

    assign halt_now = stop_on_err_i && stat_q[0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_FETCH;
            ST_FETCH: if (mem_ack_i && idx_q == LAST_IDX) state_d = ST_CHECK;
            ST_CHECK: state_d = ctrl[OWN_BIT] ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: if (cmd_ready_i) state_d = ST_WAIT;
            ST_WAIT:  if (resp_valid_i) state_d = ST_WBACK;
            ST_WBACK: if (mem_ack_i) state_d = halt_now ? ST_IDLE : ST_FETCH;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        mem_req_o   = (state_q == ST_FETCH) || (state_q == ST_WBACK);
        mem_we_o    = (state_q == ST_WBACK);
        mem_addr_o  = (state_q == ST_WBACK) ? cur_q + ADDR_W'(DONE_OFFS)
                                            : cur_q + ADDR_W'({idx_q, 2'b00});
        cmd_valid_o = (state_q == ST_ISSUE);
        cmd_flags_o = ctrl[FLAG_W-1:0];
        busy_o      = (state_q != ST_IDLE);
    end

    // datapath and event registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q        <= '0;
            idx_q        <= '0;
            xfer_q       <= '0;
            stat_q       <= '0;
            desc_done_o  <= 1'b0;
            chain_done_o <= 1'b0;
            err_stop_o   <= 1'b0;
        end else begin
            desc_done_o  <= (state_q == ST_WBACK) && mem_ack_i;
            err_stop_o   <= (state_q == ST_WBACK) && mem_ack_i && halt_now;
            chain_done_o <= (state_q == ST_CHECK) && !ctrl[OWN_BIT];
            if (state_q == ST_IDLE && start_i) begin
                cur_q <= start_addr_i;
                idx_q <= '0;
            end
            if (state_q == ST_FETCH && mem_ack_i) idx_q <= idx_q + 1'b1;
            if (state_q == ST_WAIT && resp_valid_i) begin
                xfer_q <= resp_bytes_i;
                stat_q <= resp_status_i;
            end
            if (state_q == ST_WBACK && mem_ack_i) begin
                cur_q <= next_ptr;
                idx_q <= '0;
            end
        end
    end

    // R5: a waiting command keeps its fields
    a_r5_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_rd_addr_o)
            && $stable(cmd_wr_addr_o) && $stable(cmd_len_o) && $stable(cmd_flags_o));
    // R6: every write lands on the completion word of a descriptor
    a_r6_wb_offset: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_addr_o[4:0] == 5'(DONE_OFFS));
    // R2: a pending memory request keeps its address
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
    // R8: descriptor-done follows an acknowledged write
    a_r8_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done_o |-> $past(mem_we_o && mem_ack_i));
    // R3: chain end is reported while idle
    a_r3_chain_idle: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done_o |-> !busy_o && !desc_done_o);
    // R10: error stop is reported while idle, with the write-back done
    a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_stop_o |-> !busy_o && desc_done_o);
    // R4: command and memory traffic never overlap
    a_r4_cmd_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> !mem_req_o);
endmodule

// File: tb/desc_chain_walker_tb_top.sv
`timescale 1ns/1ps
module desc_chain_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic        keep_own_i = 1'b0;
    logic        stop_on_err_i = 1'b0;
    logic        mem_req_o, mem_we_o, mem_ack_i;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        cmd_valid_o, cmd_ready_i;
    logic [31:0] cmd_rd_addr_o, cmd_wr_addr_o;
    logic [15:0] cmd_len_o;
    logic [2:0]  cmd_flags_o;
    logic        resp_valid_i = 1'b0;
    logic [15:0] resp_bytes_i;
    logic [7:0]  resp_status_i;
    logic        busy_o, desc_done_o, chain_done_o, err_stop_o;

    always #2.5 clk = ~clk;

    desc_chain_walker dut_i (.*);

    // memory model: same-cycle acknowledge
    logic [31:0] mem [0:127];
    assign mem_ack_i   = mem_req_o;
    assign mem_rdata_i = mem[mem_addr_o[8:2]];

    int          vectors = 0, miscompares = 0;
    logic [31:0] rd_log [0:63];
    logic [31:0] wr_addr_log [0:15];
    logic [31:0] wr_data_log [0:15];
    int          rd_n, wr_n, cmd_n, done_n, chain_n, err_n;
    logic [31:0] c_rd [0:7];
    logic [31:0] c_wr [0:7];
    logic [15:0] c_len [0:7];
    logic [2:0]  c_flg [0:7];
    logic        ready_en = 1'b1;
    logic [15:0] rsp_bytes = '0;
    logic [7:0]  rsp_status = '0;
    int          mv_cnt = 0;

    assign cmd_ready_i   = ready_en;
    assign resp_bytes_i  = rsp_bytes;
    assign resp_status_i = rsp_status;

    always @(posedge clk) begin
        if (mem_req_o && mem_ack_i) begin
            if (mem_we_o) begin
                mem[mem_addr_o[8:2]] <= mem_wdata_o;
                if (wr_n < 16) begin
                    wr_addr_log[wr_n] <= mem_addr_o;
                    wr_data_log[wr_n] <= mem_wdata_o;
                end
                wr_n <= wr_n + 1;
            end else begin
                if (rd_n < 64) rd_log[rd_n] <= mem_addr_o;
                rd_n <= rd_n + 1;
            end
        end
        if (cmd_valid_o && cmd_ready_i) begin
            if (cmd_n < 8) begin
                c_rd[cmd_n]  <= cmd_rd_addr_o;
                c_wr[cmd_n]  <= cmd_wr_addr_o;
                c_len[cmd_n] <= cmd_len_o;
                c_flg[cmd_n] <= cmd_flags_o;
            end
            cmd_n  <= cmd_n + 1;
            mv_cnt <= 3;
        end else if (mv_cnt > 0) begin
            mv_cnt <= mv_cnt - 1;
        end
        resp_valid_i <= (mv_cnt == 1);
        if (desc_done_o)  done_n  <= done_n + 1;
        if (chain_done_o) chain_n <= chain_n + 1;
        if (err_stop_o)   err_n   <= err_n + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic clr_logs();
        @(negedge clk);
        rd_n = 0; wr_n = 0; cmd_n = 0; done_n = 0; chain_n = 0; err_n = 0;
    endtask

    task automatic set_desc(input logic [31:0] base, input logic [31:0] ra,
                            input logic [31:0] wa, input logic [31:0] nxt,
                            input logic [15:0] len, input logic [7:0] ctl);
        mem[base[8:2] + 0] = ra;
        mem[base[8:2] + 1] = 32'hDEAD_0001;
        mem[base[8:2] + 2] = wa;
        mem[base[8:2] + 3] = 32'hDEAD_0003;
        mem[base[8:2] + 4] = nxt;
        mem[base[8:2] + 5] = 32'hDEAD_0005;
        mem[base[8:2] + 6] = {8'h44, 8'h33, len};
        mem[base[8:2] + 7] = {ctl, 8'h00, 16'h0000};
    endtask

    task automatic kick(input logic [31:0] a);
        @(negedge clk);
        start_addr_i = a;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
        if (busy_o) chk("watchdog idle", 32'(busy_o), 32'd0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 mem_req", 32'(mem_req_o), 0);
        chk("R1 cmd_valid", 32'(cmd_valid_o), 0);
        chk("R1 events", {29'd0, desc_done_o, chain_done_o, err_stop_o}, 0);
    endtask

    task automatic t_single();
        clr_logs();
        keep_own_i = 1'b0; stop_on_err_i = 1'b0;
        rsp_bytes = 16'd1500; rsp_status = 8'h80;
        set_desc(32'h100, 32'hA000_0000, 32'hB000_0010, 32'h140, 16'd0, 8'h85);
        set_desc(32'h140, 32'h1, 32'h2, 32'h180, 16'd9, 8'h00);
        kick(32'h100);
        wait_idle();
        for (int i = 0; i < 8; i++) chk("R2 fetch order", rd_log[i], 32'h100 + 32'(4 * i));
        chk("R4 cmd count", cmd_n, 1);
        chk("R4 rd addr", c_rd[0], 32'hA000_0000);
        chk("R4 wr addr", c_wr[0], 32'hB000_0010);
        chk("R4 zero len passthrough", 32'(c_len[0]), 0);
        chk("R4 flags", 32'(c_flg[0]), 32'h5);
        chk("R6 wb count", wr_n, 1);
        chk("R6 wb addr", wr_addr_log[0], 32'h11C);
        chk("R7 wb data own cleared", wr_data_log[0], {8'h05, 8'h80, 16'd1500});
        chk("R9 next fetch", rd_log[8], 32'h140);
        chk("R3 reads of end desc", rd_n, 16);
        chk("R3 chain_done", chain_n, 1);
        chk("R8 desc_done", done_n, 1);
    endtask

    task automatic t_keep_own();
        clr_logs();
        keep_own_i = 1'b1;
        rsp_bytes = 16'h0040; rsp_status = 8'h00;
        set_desc(32'h000, 32'h10, 32'h20, 32'h040, 16'd64, 8'h82);
        set_desc(32'h040, 32'h0, 32'h0, 32'h0, 16'd0, 8'h7F);
        kick(32'h000);
        wait_idle();
        chk("R7 own kept", wr_data_log[0], {8'h82, 8'h00, 16'h0040});
        chk("R4 len", 32'(c_len[0]), 64);
        chk("R4 flags rd fixed", 32'(c_flg[0]), 32'h2);
        chk("R3 non-owned with other bits", cmd_n, 1);
        keep_own_i = 1'b0;
    endtask

    task automatic t_chain_err_continue();
        clr_logs();
        stop_on_err_i = 1'b0;
        rsp_bytes = 16'd7; rsp_status = 8'h05;
        set_desc(32'h080, 32'h100, 32'h200, 32'h0C0, 16'd7, 8'h80);
        set_desc(32'h0C0, 32'h101, 32'h201, 32'h180, 16'd8, 8'h81);
        set_desc(32'h180, 32'h102, 32'h202, 32'h1A0, 16'd9, 8'h84);
        set_desc(32'h1A0, 32'h0, 32'h0, 32'h0, 16'd0, 8'h00);
        kick(32'h080);
        wait_idle();
        chk("R10 continue cmds", cmd_n, 3);
        chk("R9 third rd addr", c_rd[2], 32'h102);
        chk("R9 second desc read", rd_log[8], 32'h0C0);
        chk("R9 third desc read", rd_log[16], 32'h180);
        chk("R8 three done", done_n, 3);
        chk("R10 no stop", err_n, 0);
        chk("R6 third wb addr", wr_addr_log[2], 32'h19C);
    endtask

    task automatic t_stop_err();
        clr_logs();
        stop_on_err_i = 1'b1;
        rsp_bytes = 16'd3; rsp_status = 8'h09;
        set_desc(32'h080, 32'h100, 32'h200, 32'h0C0, 16'd7, 8'h80);
        set_desc(32'h0C0, 32'h101, 32'h201, 32'h180, 16'd8, 8'h81);
        kick(32'h080);
        wait_idle();
        chk("R10 err pulse", err_n, 1);
        chk("R10 one cmd", cmd_n, 1);
        chk("R10 no further read", rd_n, 8);
        chk("R10 wb status", wr_data_log[0], {8'h00, 8'h09, 16'd3});
        chk("R10 no chain_done", chain_n, 0);
        stop_on_err_i = 1'b0;
    endtask

    task automatic t_hold_and_busy_start();
        logic [31:0] ra;
        logic [15:0] ln;
        clr_logs();
        ready_en = 1'b0;
        rsp_bytes = 16'd2; rsp_status = 8'h00;
        set_desc(32'h100, 32'hCAFE_0000, 32'hF00D_0000, 32'h140, 16'h1234, 8'h81);
        set_desc(32'h140, 32'h0, 32'h0, 32'h0, 16'd0, 8'h00);
        set_desc(32'h1C0, 32'h0, 32'h0, 32'h0, 16'd0, 8'h80);
        kick(32'h100);
        for (int i = 0; i < 20; i++) begin
            if (cmd_valid_o) break;
            @(negedge clk);
        end
        ra = cmd_rd_addr_o; ln = cmd_len_o;
        chk("R4 cmd offered", 32'(cmd_valid_o), 1);
        start_addr_i = 32'h1C0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R5 valid held", 32'(cmd_valid_o), 1);
            chk("R5 addr held", cmd_rd_addr_o, ra);
            chk("R5 len held", 32'(cmd_len_o), 32'(ln));
        end
        ready_en = 1'b1;
        wait_idle();
        chk("R5 accepted once", cmd_n, 1);
        chk("R11 start ignored", rd_n, 16);
        chk("R11 no cmd from ignored start", c_rd[0], 32'hCAFE_0000);
    endtask

    task automatic t_first_unowned();
        clr_logs();
        set_desc(32'h1C0, 32'h5, 32'h6, 32'h100, 16'd4, 8'h07);
        kick(32'h1C0);
        wait_idle();
        chk("R3 no cmd", cmd_n, 0);
        chk("R3 no write", wr_n, 0);
        chk("R3 chain_done", chain_n, 1);
        chk("R3 reads", rd_n, 8);
        chk("R3 busy low", 32'(busy_o), 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        rd_n = 0; wr_n = 0; cmd_n = 0; done_n = 0; chain_n = 0; err_n = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_keep_own();
        t_chain_err_continue();
        t_stop_err();
        t_hold_and_busy_start();
        t_first_unowned();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule